// File: doc/BRIEF.md
# DMA Status and Interrupt Register Bank

This block is the software-visible register bank of a descriptor DMA controller. A processor reaches it through a word-addressed read/write port and uses it to set bus behaviour, point the receive and transmit engines at their descriptor rings, start or stop those engines through a control word, and choose which events raise the interrupt. The DMA words begin at word index `DMA_BASE` (0x3C0 by default). A read-only identification word sits at word index 0x8.

The transmit and receive engines report events on a one-cycle event vector. Each event sets a sticky bit in the status word, and the matching normal or abnormal summary bit is set along with it. Software reads the status word and clears bits by writing ones. A single level interrupt output is high while any status bit is both set and enabled.

The register port has no back-pressure. It accepts a write in every cycle where `csr_en` and `csr_we` are both high. Read data is combinational from `csr_addr`. Engine-facing outputs are plain levels or pulses with no handshake.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every register (bus mode, control, interrupt enable, status, both ring bases and both current pointers) reads 0, and `irq_o` and `soft_rst_o` are low.
- R2: Word index 0x8 always reads 0x1012, and writes to it have no effect. Unmapped word indices, including DMA_BASE+1, DMA_BASE+2 and 0x3FF, read 0.
- R3: Writing the receive ring base (DMA_BASE+3) or the transmit ring base (DMA_BASE+4) stores the value and loads it into the matching current pointer: receive at DMA_BASE+0x13, transmit at DMA_BASE+0x12. Writing a current pointer directly changes only that pointer.
- R4: The bus mode word (DMA_BASE+0) stores what is written, but bit 0 always reads 0. Writing it with bit 0 set drives `soft_rst_o` high for exactly the following cycle.
- R5: Writing the status word (DMA_BASE+5) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R6: A 1 on `evt_in[k]` for k < 17 sets status bit k, which stays set until software clears it. Event bits 17 and above are ignored, and status bits above 16 read 0.
- R7: An event in the normal group {0, 2, 6, 14} also sets the normal summary bit 16. An event in the abnormal group {1, 3, 4, 5, 7, 8, 9, 10, 13} also sets the abnormal summary bit 15. Transmit done is bit 0, receive done is bit 6, and receive-buffer-unavailable is bit 7.
- R8: When an event and a software clear hit the same status bit in one cycle, the bit ends up set.
- R9: `irq_o` is high exactly when (status AND interrupt enable) is non-zero. The interrupt enable word is at DMA_BASE+7. `irq_o` follows the register values from the cycle after the write or event that changes them.
- R10: The control word (DMA_BASE+6) stores the full written value and drives it on `ctrl_o`. The stored bus mode drives `bus_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Register access strobe |
| csr_we | input | 1 | Write when high, read when low |
| csr_addr | input | ADDR_W | Word index |
| csr_wdata | input | DW | Write data |
| csr_rdata | output | DW | Read data for `csr_addr` (combinational) |
| evt_in | input | DW | One-cycle event pulses from the engines |
| irq_o | output | 1 | Level interrupt |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| bus_mode_o | output | DW | Stored bus mode, bit 0 forced to 0 |
| ctrl_o | output | DW | Control word |
| rx_cur_o | output | DW | Receive current descriptor pointer |
| tx_cur_o | output | DW | Transmit current descriptor pointer |

## Verification
The assertions assume that the engines present each event for one cycle only, and that the port presents at most one access per cycle. They also assume that status clears checked for full effect arrive in cycles without events. The stimulus drives every access and every event pulse for exactly one cycle. Clears on their own happen in event-free cycles. Same-cycle collision of an event and a clear is produced only on purpose, and that case is covered by the set-wins property instead.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int STAT_W      = 17;
  localparam int OFF_BUSMODE = 'h00;
  localparam int OFF_RXBASE  = 'h03;
  localparam int OFF_TXBASE  = 'h04;
  localparam int OFF_STATUS  = 'h05;
  localparam int OFF_CTRL    = 'h06;
  localparam int OFF_IEN     = 'h07;
  localparam int OFF_TXCUR   = 'h12;
  localparam int OFF_RXCUR   = 'h13;
  localparam int ID_INDEX    = 'h08;
  localparam logic [31:0] ID_VALUE = 32'h0000_1012;

  // summary bit positions and the event groups feeding them
  localparam int BIT_NORM_SUM = 16;
  localparam int BIT_ABN_SUM  = 15;
  localparam logic [STAT_W-1:0] NORM_GRP = 17'h0_4045;
  localparam logic [STAT_W-1:0] ABN_GRP  = 17'h0_27BA;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BUSMODE,
    SEL_RXBASE,
    SEL_TXBASE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_IEN,
    SEL_RXCUR,
    SEL_TXCUR,
    SEL_ID
  } reg_sel_e;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DMA_BASE = 'h3C0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_BUSM = ADDR_W'(DMA_BASE + OFF_BUSMODE);
  localparam logic [ADDR_W-1:0] A_RXB  = ADDR_W'(DMA_BASE + OFF_RXBASE);
  localparam logic [ADDR_W-1:0] A_TXB  = ADDR_W'(DMA_BASE + OFF_TXBASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(DMA_BASE + OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DMA_BASE + OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(DMA_BASE + OFF_IEN);
  localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'(DMA_BASE + OFF_RXCUR);
  localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'(DMA_BASE + OFF_TXCUR);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(ID_INDEX);

  always_comb begin
    sel = SEL_NONE;
    case (addr)
      A_BUSM:  sel = SEL_BUSMODE;
      A_RXB:   sel = SEL_RXBASE;
      A_TXB:   sel = SEL_TXBASE;
      A_STAT:  sel = SEL_STATUS;
      A_CTRL:  sel = SEL_CTRL;
      A_IEN:   sel = SEL_IEN;
      A_RXC:   sel = SEL_RXCUR;
      A_TXC:   sel = SEL_TXCUR;
      A_ID:    sel = SEL_ID;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dma_csr_cfg.sv
module dma_csr_cfg
  import dma_csr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bus_mode,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] ien,
  output logic [DW-1:0] rx_base,
  output logic [DW-1:0] tx_base,
  output logic [DW-1:0] rx_cur,
  output logic [DW-1:0] tx_cur,
  output logic          soft_rst
);
  localparam int NRING = 2;  // ring 0 = receive, ring 1 = transmit
  localparam logic [DW-1:0] SRST_MASK = DW'(1);

  logic [DW-1:0] base_q [NRING];
  logic [DW-1:0] cur_q  [NRING];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_mode <= '0;
      ctrl     <= '0;
      ien      <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= wr && (sel == SEL_BUSMODE) && wdata[0];
      if (wr && sel == SEL_BUSMODE) bus_mode <= wdata & ~SRST_MASK;
      if (wr && sel == SEL_CTRL)    ctrl     <= wdata;
      if (wr && sel == SEL_IEN)     ien      <= wdata;
    end
  end

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    localparam reg_sel_e BSEL = (g == 0) ? SEL_RXBASE : SEL_TXBASE;
    localparam reg_sel_e CSEL = (g == 0) ? SEL_RXCUR  : SEL_TXCUR;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        cur_q[g]  <= '0;
      end else if (wr && sel == BSEL) begin
        base_q[g] <= wdata;
        cur_q[g]  <= wdata;
      end else if (wr && sel == CSEL) begin
        cur_q[g]  <= wdata;
      end
    end
  end

  assign rx_base = base_q[0];
  assign tx_base = base_q[1];
  assign rx_cur  = cur_q[0];
  assign tx_cur  = cur_q[1];
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] evt,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] set_bits;
  logic [STAT_W-1:0] keep_bits;

  always_comb begin
    set_bits = evt;
    if (|(evt & NORM_GRP)) set_bits[BIT_NORM_SUM] = 1'b1;
    if (|(evt & ABN_GRP))  set_bits[BIT_ABN_SUM]  = 1'b1;
    keep_bits = clr_en ? (stat & ~clr_bits) : stat;
  end

  // an event in the same cycle as a clear overrides it
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= keep_bits | set_bits;
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DW       = 32,
  parameter int DMA_BASE = 'h3C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  output logic [DW-1:0]     csr_rdata,
  input  logic [DW-1:0]     evt_in,
  output logic              irq_o,
  output logic              soft_rst_o,
  output logic [DW-1:0]     bus_mode_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     rx_cur_o,
  output logic [DW-1:0]     tx_cur_o
);
  reg_sel_e          sel;
  logic              wr;
  logic [DW-1:0]     ien_w, rxb_w, txb_w;
  logic [STAT_W-1:0] stat_w;
  logic [DW-1:0]     stat_ext;
  logic              unused_evt_hi;

  assign wr            = csr_en && csr_we;
  assign unused_evt_hi = ^evt_in[DW-1:STAT_W];
  assign stat_ext      = {{(DW-STAT_W){1'b0}}, stat_w};

  dma_csr_decode #(.ADDR_W(ADDR_W), .DMA_BASE(DMA_BASE)) u_dec (
    .addr (csr_addr),
    .sel  (sel)
  );

  dma_csr_cfg #(.DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .sel      (sel),
    .wdata    (csr_wdata),
    .bus_mode (bus_mode_o),
    .ctrl     (ctrl_o),
    .ien      (ien_w),
    .rx_base  (rxb_w),
    .tx_base  (txb_w),
    .rx_cur   (rx_cur_o),
    .tx_cur   (tx_cur_o),
    .soft_rst (soft_rst_o)
  );

  dma_csr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr && sel == SEL_STATUS),
    .clr_bits (csr_wdata[STAT_W-1:0]),
    .evt      (evt_in[STAT_W-1:0]),
    .stat     (stat_w)
  );

  assign irq_o = |(stat_ext & ien_w);

  always_comb begin
    case (sel)
      SEL_BUSMODE: csr_rdata = bus_mode_o;
      SEL_RXBASE:  csr_rdata = rxb_w;
      SEL_TXBASE:  csr_rdata = txb_w;
      SEL_STATUS:  csr_rdata = stat_ext;
      SEL_CTRL:    csr_rdata = ctrl_o;
      SEL_IEN:     csr_rdata = ien_w;
      SEL_RXCUR:   csr_rdata = rx_cur_o;
      SEL_TXCUR:   csr_rdata = tx_cur_o;
      SEL_ID:      csr_rdata = DW'(ID_VALUE);
      default:     csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DW       = 32,
  parameter int DMA_BASE = 'h3C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_en,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DW-1:0]     csr_wdata,
  input logic [DW-1:0]     evt_in,
  input logic              irq_o,
  input logic              soft_rst_o,
  input logic [DW-1:0]     rx_cur_o,
  input logic [STAT_W-1:0] stat
);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(DMA_BASE + OFF_STATUS);
  localparam logic [ADDR_W-1:0] C_IEN  = ADDR_W'(DMA_BASE + OFF_IEN);
  localparam logic [ADDR_W-1:0] C_RXB  = ADDR_W'(DMA_BASE + OFF_RXBASE);
  localparam logic [ADDR_W-1:0] C_BUSM = ADDR_W'(DMA_BASE + OFF_BUSMODE);

  logic              w_stat, w_ien, w_rxb, w_busm, any_evt;
  logic [STAT_W-1:0] ev;
  assign w_stat  = csr_en && csr_we && (csr_addr == C_STAT);
  assign w_ien   = csr_en && csr_we && (csr_addr == C_IEN);
  assign w_rxb   = csr_en && csr_we && (csr_addr == C_RXB);
  assign w_busm  = csr_en && csr_we && (csr_addr == C_BUSM);
  assign ev      = evt_in[STAT_W-1:0];
  assign any_evt = |ev;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !any_evt) |=> ((stat & $past(csr_wdata[STAT_W-1:0])) == '0)); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !w_stat |=> ((~stat & $past(stat)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> ((stat & $past(ev)) == $past(ev))); // R8
  AST_NORM_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & NORM_GRP)) |=> stat[BIT_NORM_SUM]); // R7
  AST_BASE_LOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    w_rxb |=> (rx_cur_o == $past(csr_wdata))); // R3
  AST_SRST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(w_busm && csr_wdata[0])); // R4
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(w_stat || w_ien)); // R9
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_evt || w_ien)); // R9
endmodule

bind dma_csr_bank dma_csr_bank_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .DMA_BASE(DMA_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_en     (csr_en),
  .csr_we     (csr_we),
  .csr_addr   (csr_addr),
  .csr_wdata  (csr_wdata),
  .evt_in     (evt_in),
  .irq_o      (irq_o),
  .soft_rst_o (soft_rst_o),
  .rx_cur_o   (rx_cur_o),
  .stat       (stat_w)
);

// File: tb/dma_csr_bank_tb.sv
`timescale 1ns/1ps
module dma_csr_bank_tb;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_en = 1'b0, csr_we = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0, evt_in = '0;
  logic [DW-1:0] csr_rdata, bus_mode_o, ctrl_o, rx_cur_o, tx_cur_o;
  logic          irq_o, soft_rst_o;
  int            n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  dma_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .evt_in(evt_in), .irq_o(irq_o), .soft_rst_o(soft_rst_o),
    .bus_mode_o(bus_mode_o), .ctrl_o(ctrl_o),
    .rx_cur_o(rx_cur_o), .tx_cur_o(tx_cur_o)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'h3C0, 32'h0000_00A5, 32'h0},  // R4 bus mode
    '{1'b0, 10'h3C0, 32'h0,         32'h0000_00A4},
    '{1'b1, 10'h3C6, 32'h0000_2002, 32'h0},  // R10 control
    '{1'b0, 10'h3C6, 32'h0,         32'h0000_2002},
    '{1'b1, 10'h3C3, 32'h0000_1000, 32'h0},  // R3 rx base
    '{1'b0, 10'h3C3, 32'h0,         32'h0000_1000},
    '{1'b0, 10'h3D3, 32'h0,         32'h0000_1000},
    '{1'b1, 10'h3C4, 32'h0000_2000, 32'h0},  // R3 tx base
    '{1'b0, 10'h3D2, 32'h0,         32'h0000_2000},
    '{1'b1, 10'h3D3, 32'h0000_1040, 32'h0},  // R3 direct pointer write
    '{1'b0, 10'h3D3, 32'h0,         32'h0000_1040},
    '{1'b0, 10'h3C3, 32'h0,         32'h0000_1000},
    '{1'b0, 10'h008, 32'h0,         32'h0000_1012},  // R2 id word
    '{1'b1, 10'h008, 32'h0000_FFFF, 32'h0},
    '{1'b0, 10'h008, 32'h0,         32'h0000_1012},
    '{1'b0, 10'h3C1, 32'h0,         32'h0},           // R2 unmapped
    '{1'b0, 10'h3FF, 32'h0,         32'h0},
    '{1'b1, 10'h3C7, 32'h0000_0041, 32'h0},  // R9 enable
    '{1'b0, 10'h3C7, 32'h0,         32'h0000_0041}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] ev);
    @(negedge clk);
    csr_en = we; csr_we = we; csr_addr = a; csr_wdata = d; evt_in = ev;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0; evt_in = '0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    csr_addr = a;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 bus mode", 10'h3C0, 0);
    rd("R1 rx base", 10'h3C3, 0);
    rd("R1 tx base", 10'h3C4, 0);
    rd("R1 status", 10'h3C5, 0);
    rd("R1 control", 10'h3C6, 0);
    rd("R1 enable", 10'h3C7, 0);
    rd("R1 tx cur", 10'h3D2, 0);
    rd("R1 rx cur", 10'h3D3, 0);
    chk("R1 irq", DW'(irq_o), 0);
    chk("R1 soft reset", DW'(soft_rst_o), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) access(1'b1, VECS[i].addr, VECS[i].data, '0);
      else begin
        @(negedge clk);
        rd($sformatf("R2/R3/R4/R9/R10 vector %0d", i), VECS[i].addr, VECS[i].exp);
      end
    end
    chk("R10 ctrl_o", ctrl_o, 32'h2002);
    chk("R10 bus_mode_o", bus_mode_o, 32'hA4);
    chk("R3 rx_cur_o", rx_cur_o, 32'h1040);
    chk("R3 tx_cur_o", tx_cur_o, 32'h2000);

    // events: enable is 0x41 (bits 0 and 6)
    access(1'b0, 10'h0, 0, 32'h0000_0001);
    rd("R6 R7 tx done sets bit0 and bit16", 10'h3C5, 32'h0001_0001);
    chk("R9 irq after enabled event", DW'(irq_o), 1);
    access(1'b0, 10'h0, 0, 32'h0000_0080);
    rd("R7 rx unavailable sets bit7 and bit15", 10'h3C5, 32'h0001_8081);
    access(1'b0, 10'h0, 0, 32'hFFFE_0000);
    rd("R6 upper event bits ignored", 10'h3C5, 32'h0001_8081);
    access(1'b1, 10'h3C5, 32'h0000_0001, '0);
    rd("R5 write one clears bit0", 10'h3C5, 32'h0001_8080);
    chk("R9 irq low with no enabled bit set", DW'(irq_o), 0);
    access(1'b1, 10'h3C5, 32'h0, '0);
    rd("R5 write zero leaves status", 10'h3C5, 32'h0001_8080);
    access(1'b1, 10'h3C5, 32'h0000_0040, 32'h0000_0040);
    rd("R8 set beats clear", 10'h3C5, 32'h0001_80C0);
    chk("R9 irq from rx done", DW'(irq_o), 1);
    access(1'b1, 10'h3C7, 32'h0, '0);
    chk("R9 irq drops when enable cleared", DW'(irq_o), 0);
    access(1'b1, 10'h3C7, 32'h0000_8000, '0);
    chk("R9 irq from abnormal summary", DW'(irq_o), 1);
    access(1'b1, 10'h3C5, 32'h0001_FFFF, '0);
    rd("R5 clear all", 10'h3C5, 32'h0);
    chk("R9 irq after clear all", DW'(irq_o), 0);

    // R4 soft reset pulse
    access(1'b1, 10'h3C0, 32'h0000_0001, '0);
    chk("R4 soft reset pulse high", DW'(soft_rst_o), 1);
    rd("R4 bit0 reads zero", 10'h3C0, 32'h0);
    @(negedge clk);
    chk("R4 soft reset pulse one cycle", DW'(soft_rst_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule